// File: doc/BRIEF.md
# Dual-Ramp Charge-Transfer Phase Sequencer

This controller drives one stage of a pipelined converter whose residue amplifier works by zero-crossing detection rather than by an op-amp. Every conversion cycle it leaves the sampling phase and walks through three charge-transfer phases in a fixed order. First comes a preset phase, in which a short pulse forces the stage outputs to opposite rails. Next is a fast coarse ramp, which ends when a coarse threshold detector trips. Last is a slow fine ramp, which ends when the zero-crossing detector trips. The flash comparators of the next stage are strobed as soon as the coarse ramp ends. They do not wait for the fine ramp, so the comparators get more decision time without taking any time away from charge transfer.

Once the crossing has been seen, the downstream sampling switch opens first. One cycle later the fine ramp current is removed. The detector and ramp bias enables then stay low until the next cycle's preset, which saves idle power at low conversion rates. Both detector flags are asynchronous and each passes through a two-flop synchronizer. A flag that arrives outside its own phase does nothing. If a crossing never arrives within its programmed window, a timeout ends the phase and sets a sticky error flag.

The block has no data stream, so every pin is a plain control or status level.

Top module: `zx_phase_seq`

## Requirements
- R1: After reset the sequencer waits for `samp_ph` high (sampling phase). The first clock edge at which `samp_ph` is low after that starts the preset phase. The phases always run in the order sampling, preset, coarse, fine, release and idle.
- R2: The preset pulse `preset_p` is high for exactly `preset_len` clock cycles, and a value of 0 is treated as 1. During those cycles `coarse_en`, `fine_en`, `samp_sw`, `ramp_pwr` and `zcd_pwr` are all high. The coarse phase starts in the first cycle after the pulse ends.
- R3: When the coarse phase ends, `coarse_en` falls. In that same cycle `flash_strobe` is high for exactly one cycle, while `fine_en`, `samp_sw`, `ramp_pwr` and `zcd_pwr` stay high.
- R4: When the fine phase ends, `samp_sw` and `zcd_pwr` fall. For exactly one further cycle `fine_en` and `ramp_pwr` stay high, and then they also fall. All enables then stay low until the next preset.
- R5: Each flag is seen through two synchronizer flops. A flag that is high at clock edge k ends its phase at edge k+2.
- R6: A coarse flag seen outside the coarse phase has no effect, and neither does a fine flag seen outside the fine phase. This includes flags seen while idle, during sampling and during preset.
- R7: If no coarse flag is seen within `crs_win` cycles of the coarse phase (0 treated as 1), the phase ends on its last cycle as in R3, strobe included, and `timeout_err` rises in the first fine cycle.
- R8: If no fine flag is seen within `fin_win` cycles of the fine phase (0 treated as 1), the phase ends as in R4 and `timeout_err` rises in the release cycle.
- R9: `timeout_err` stays high until reset, across later good cycles.
- R10: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset |
| samp_ph | input | 1 | Sampling phase, high while the stage samples |
| crs_flag_a | input | 1 | Coarse threshold detector output, asynchronous |
| fin_flag_a | input | 1 | Fine zero-crossing detector output, asynchronous |
| preset_len | input | CNT_W | Preset pulse width in cycles |
| crs_win | input | CNT_W | Coarse phase timeout window in cycles |
| fin_win | input | CNT_W | Fine phase timeout window in cycles |
| preset_p | output | 1 | Preset pulse to the output rails |
| coarse_en | output | 1 | Coarse ramp enable; also clamps the level-shift nodes |
| fine_en | output | 1 | Fine ramp current enable |
| samp_sw | output | 1 | Downstream sampling-switch control |
| flash_strobe | output | 1 | One-cycle strobe for the next stage's flash comparators |
| ramp_pwr | output | 1 | Ramp current source power enable |
| zcd_pwr | output | 1 | Detector power enable |
| timeout_err | output | 1 | Sticky crossing timeout flag |

## Verification
The first pattern is a plain cycle with short flag delays. It pins down the phase order, the length of the preset pulse and the two-edge synchronizer latency. A second pattern uses a zero preset length with immediate flags, which separates the minimum-width rule from ordinary counting. A third drives stray pulses of both flags during preset, a fine pulse during the coarse ramp and a coarse pulse during the fine ramp. It shows whether the state machine takes each flag only in its own phase. Missing-flag cycles for each ramp separate the coarse timeout, which still strobes, from the fine timeout. A good cycle run after them shows that the error holds until a reset clears it.

// File: rtl/zx_seq_pkg.sv
package zx_seq_pkg;
  typedef enum logic [2:0] {
    PH_WAIT = 3'd0,
    PH_SAMP = 3'd1,
    PH_PRE  = 3'd2,
    PH_CRS  = 3'd3,
    PH_FIN  = 3'd4,
    PH_OFF  = 3'd5
  } zx_phase_e;
endpackage

// File: rtl/zx_sync.sv
module zx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/zx_dwell_timer.sv
module zx_dwell_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (cnt != CNT_MAX)   cnt <= cnt + ONE;
  end

  assign lim_eff = (limit == '0) ? ONE : limit;
  assign expire  = (cnt == lim_eff - ONE);

  AST_CNT_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !$past(expire) || (limit != ONE && limit != '0) || expire); // R2
endmodule

// File: rtl/zx_phase_decode.sv
module zx_phase_decode
  import zx_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  zx_phase_e ph,
  output logic      preset_p,
  output logic      coarse_en,
  output logic      fine_en,
  output logic      samp_sw,
  output logic      ramp_pwr,
  output logic      zcd_pwr
);
  logic in_xfer;

  assign in_xfer   = (ph == PH_PRE) || (ph == PH_CRS) || (ph == PH_FIN);
  assign preset_p  = (ph == PH_PRE);
  assign coarse_en = (ph == PH_PRE) || (ph == PH_CRS);
  assign samp_sw   = in_xfer;
  assign zcd_pwr   = in_xfer;
  assign fine_en   = in_xfer || (ph == PH_OFF);
  assign ramp_pwr  = in_xfer || (ph == PH_OFF);

  AST_COARSE_NEEDS_FINE: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_en |-> fine_en && ramp_pwr); // R2
endmodule

// File: rtl/zx_phase_seq.sv
module zx_phase_seq
  import zx_seq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_ph,
  input  logic             crs_flag_a,
  input  logic             fin_flag_a,
  input  logic [CNT_W-1:0] preset_len,
  input  logic [CNT_W-1:0] crs_win,
  input  logic [CNT_W-1:0] fin_win,
  output logic             preset_p,
  output logic             coarse_en,
  output logic             fine_en,
  output logic             samp_sw,
  output logic             flash_strobe,
  output logic             ramp_pwr,
  output logic             zcd_pwr,
  output logic             timeout_err
);
  localparam int FLAG_N = 2;

  zx_phase_e        ph_q, ph_next;
  logic [FLAG_N-1:0] flags_s;
  logic             crs_s, fin_s;
  logic             restart, expire;
  logic [CNT_W-1:0] limit;
  logic             crs_to, fin_to;
  logic             strobe_q, err_q;

  zx_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fin_flag_a, crs_flag_a}),
    .q     (flags_s)
  );
  assign crs_s = flags_s[0];
  assign fin_s = flags_s[1];

  always_comb begin
    unique case (ph_q)
      PH_CRS:  limit = crs_win;
      PH_FIN:  limit = fin_win;
      default: limit = preset_len;
    endcase
  end

  zx_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .limit   (limit),
    .expire  (expire)
  );

  assign crs_to = (ph_q == PH_CRS) && !crs_s && expire;
  assign fin_to = (ph_q == PH_FIN) && !fin_s && expire;

  always_comb begin
    ph_next = ph_q;
    unique case (ph_q)
      PH_WAIT: if (samp_ph)          ph_next = PH_SAMP;
      PH_SAMP: if (!samp_ph)         ph_next = PH_PRE;
      PH_PRE:  if (expire)           ph_next = PH_CRS;
      PH_CRS:  if (crs_s || expire)  ph_next = PH_FIN;
      PH_FIN:  if (fin_s || expire)  ph_next = PH_OFF;
      PH_OFF:                        ph_next = PH_WAIT;
      default:                       ph_next = PH_WAIT;
    endcase
  end

  assign restart = (ph_next != ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_WAIT;
      strobe_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      ph_q     <= ph_next;
      strobe_q <= (ph_q == PH_CRS) && (ph_next == PH_FIN);
      err_q    <= err_q || crs_to || fin_to;
    end
  end

  zx_phase_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph_q),
    .preset_p  (preset_p),
    .coarse_en (coarse_en),
    .fine_en   (fine_en),
    .samp_sw   (samp_sw),
    .ramp_pwr  (ramp_pwr),
    .zcd_pwr   (zcd_pwr)
  );

  assign flash_strobe = strobe_q;
  assign timeout_err  = err_q;

  AST_PRESET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    preset_p |-> coarse_en && fine_en && samp_sw && zcd_pwr); // R2
  AST_PRESET_TO_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(preset_p) |-> coarse_en); // R1
  AST_STROBE_ON_COARSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coarse_en) |-> flash_strobe && fine_en && samp_sw); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flash_strobe |=> !flash_strobe); // R3
  AST_SWITCH_BEFORE_FINE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fine_en) |-> $past(!samp_sw)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err); // R9
endmodule

// File: tb/test_zx_phase_seq.sv
module test_zx_phase_seq;
  localparam int CW = 8;
  localparam int W_ = 0, S_ = 1, P_ = 2, C_ = 3, F_ = 4, O_ = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, samp_ph = 1'b0, crs_flag_a = 1'b0, fin_flag_a = 1'b0;
  logic [CW-1:0] preset_len = 8'd2, crs_win = 8'd20, fin_win = 8'd20;
  logic preset_p, coarse_en, fine_en, samp_sw, flash_strobe, ramp_pwr, zcd_pwr, timeout_err;

  zx_phase_seq #(.CNT_W(CW)) i_zx_phase_seq (
    .clk(clk), .rst_n(rst_n), .samp_ph(samp_ph), .crs_flag_a(crs_flag_a),
    .fin_flag_a(fin_flag_a), .preset_len(preset_len), .crs_win(crs_win),
    .fin_win(fin_win), .preset_p(preset_p), .coarse_en(coarse_en),
    .fine_en(fine_en), .samp_sw(samp_sw), .flash_strobe(flash_strobe),
    .ramp_pwr(ramp_pwr), .zcd_pwr(zcd_pwr), .timeout_err(timeout_err)
  );

  int n_run = 0, n_fail = 0;
  bit exp_err = 1'b0, finished = 1'b0;
  logic [7:0] expq[$];
  string tagq[$];

  // vector: preset, coarse, fine, switch, strobe, ramp, zcd, err
  function automatic logic [7:0] vec(int ph, bit stb, bit err);
    logic [7:0] v = '0;
    case (ph)
      P_: v[7:1] = 7'b1111011;
      C_: v[7:1] = 7'b0111011;
      F_: v[7:1] = 7'b0011011;
      O_: v[7:1] = 7'b0010010;
      default: v[7:1] = '0;
    endcase
    v[3] = stb;
    v[0] = err;
    return v;
  endfunction

  // driver: set inputs after a falling edge, queue the value expected one edge later
  task automatic step(bit sp, bit cf, bit ff, int ph, bit stb, string tag);
    @(negedge clk); #1;
    samp_ph = sp; crs_flag_a = cf; fin_flag_a = ff;
    expq.push_back(vec(ph, stb, exp_err));
    tagq.push_back(tag);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (expq.size() > 0) begin
      logic [7:0] e, g;
      string t;
      e = expq.pop_front(); t = tagq.pop_front();
      g = {preset_p, coarse_en, fine_en, samp_sw, flash_strobe, ramp_pwr, zcd_pwr, timeout_err};
      n_run++;
      if (g !== e) begin
        n_fail++;
        $display("FAIL %s got %b exp %b", t, g, e);
      end
    end
  end

  task automatic xfer(int plen, int cd, int fd, int cw, int fw,
                      int pre_stray, int fin_in_crs, int crs_in_fin);
    int l, nc, nf;
    bit cto, fto;
    preset_len = CW'(plen); crs_win = CW'(cw); fin_win = CW'(fw);
    l = (plen == 0) ? 1 : plen;
    cto = !(cd >= 0 && cd + 2 <= cw);
    nc = cto ? cw : cd + 2;
    fto = !(fd >= 0 && fd + 2 <= fw);
    nf = fto ? fw : fd + 2;
    step(1, 0, 0, S_, 0, "R1 sampling");
    for (int k = 0; k < l; k++)
      step(0, k == pre_stray, k == pre_stray, P_, 0, "R2/R6 preset");
    for (int k = 0; k < nc; k++)
      step(0, k == cd, k == fin_in_crs, C_, 0, "R5/R6/R7 coarse");
    if (cto) exp_err = 1'b1;
    for (int k = 0; k < nf; k++)
      step(0, k == crs_in_fin, k == fd, F_, k == 0, "R3/R5/R6 fine");
    if (fto) exp_err = 1'b1;
    step(0, 0, 0, O_, 0, "R4/R8 release");
    step(0, 0, 0, W_, 0, "R4/R9 idle");
  endtask

  task automatic drain();
    while (expq.size() > 0) @(negedge clk);
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0; samp_ph = 1'b0; crs_flag_a = 1'b0; fin_flag_a = 1'b0;
    exp_err = 1'b0;
    repeat (2) @(negedge clk);
    n_run++;
    if ({preset_p, coarse_en, fine_en, samp_sw, flash_strobe, ramp_pwr, zcd_pwr, timeout_err} !== 8'h00) begin
      n_fail++;
      $display("FAIL R10 reset outputs got %b exp %b",
               {preset_p, coarse_en, fine_en, samp_sw, flash_strobe, ramp_pwr, zcd_pwr, timeout_err}, 8'h00);
    end
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R6: flags while idle are ignored
    step(0, 1, 1, W_, 0, "R6 idle flags");
    step(0, 0, 0, W_, 0, "R6 idle flags");
    step(0, 0, 0, W_, 0, "R6 idle flags");
    // R1: long sampling phase holds
    step(1, 0, 0, S_, 0, "R1 wait to sample");
    step(1, 1, 1, S_, 0, "R1/R6 sampling held");
    step(1, 0, 0, S_, 0, "R1 sampling held");
    step(1, 0, 0, S_, 0, "R1 sampling held");
    // normal cycle
    xfer(3, 2, 3, 20, 20, -1, -1, -1);
    // R2: zero preset length acts as one, immediate flags
    xfer(0, 0, 0, 20, 20, -1, -1, -1);
    // R6: stray flags in preset, fine in coarse, coarse in fine
    xfer(4, 5, 4, 20, 20, 0, 1, 0);
    // R7: coarse timeout with strobe
    xfer(2, -1, 1, 5, 20, -1, -1, -1);
    // R9: error holds through a good cycle
    xfer(1, 1, 2, 20, 20, -1, -1, -1);
    drain();
    do_reset();
    // R8: fine timeout
    xfer(2, 1, -1, 20, 6, -1, -1, -1);
    xfer(2, 0, 0, 20, 20, -1, -1, -1);
    drain();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule